// File: doc/BRIEF.md
# Single-Operand Shift and Flag Unit

This block is a purely combinational datapath slice that applies one single-operand operation to a 16-bit destination word. It returns the new word, a write strobe telling the surrounding datapath whether the word should be stored back, and the four condition codes for the status word. The operations are clear, test, increment, decrement, add carry, subtract carry, shift left, arithmetic shift right, rotate right through carry and byte swap.

The caller presents an operation code, the operand and the current carry flag. All outputs follow the inputs in the same cycle with no internal state. The flag nibble is packed so that it can be merged directly into the low four bits of a processor status word.

Top module: `sop_shift_flag_unit`

## Requirements
- R1: Operation codes on `op_i`: 0 clear, 1 test, 2 increment, 3 decrement, 4 add carry, 5 subtract carry, 6 shift left, 7 arithmetic shift right, 8 rotate right through carry, 9 byte swap. Flags on `cc_o` are packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R2: For every writing operation other than byte swap, N equals result bit 15 and Z is 1 exactly when the result is zero.
- R3: Shift left moves every bit up one place, puts 0 in bit 0 and sends the old bit 15 to C.
- R4: Arithmetic shift right moves every bit down one place, keeps bit 15, and sends the old bit 0 to C.
- R5: Rotate right moves every bit down one place, puts the incoming carry into bit 15 and sends the old bit 0 to C.
- R6: For shift left, arithmetic shift right and rotate right, V equals N XOR the new C.
- R7: Byte swap exchanges the two bytes; N is bit 7 and Z marks a zero low byte of the result; V and C are 0; the incoming carry has no effect.
- R8: Add carry returns operand plus `c_i`, with C set on a carry out of bit 15 and V set only when 0x7FFF becomes 0x8000. Subtract carry returns operand minus `c_i`, with C set on a borrow (0x0000 with carry in) and V set only when 0x8000 becomes 0x7FFF.
- R9: Increment sets V only for 0x7FFF to 0x8000; decrement sets V only for 0x8000 to 0x7FFF; both pass `c_i` to C unchanged.
- R10: Clear returns 0 with N=0, Z=1, V=0, C=0, whatever the operand.
- R11: Test drives `wr_o` low, returns the operand unchanged, sets N and Z from it and clears V and C.
- R12: Codes 10 to 15 are reserved: `wr_o` low, result equals the operand, all four flags 0.
- R13: `wr_o` is high for codes 0 and 2 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select |
| opnd_i | input | 16 | Destination operand |
| c_i | input | 1 | Current carry flag |
| res_o | output | 16 | Operation result |
| wr_o | output | 1 | Result should be written back |
| cc_o | output | 4 | Flags: N, Z, V, C in bits 3..0 |

## Verification
Every output of this unit is due in the same cycle as its inputs, with zero registers between them. The bench therefore applies each operand set just after a rising clock edge and compares the result, write strobe and flag nibble at the following falling edge, half a period later, so settling is never in question. Each directed scenario covers the flag edge values of its operation, such as the signed overflow boundaries and carry-in with the all-ones or all-zeros word.

// File: rtl/sop_shift_flag_unit.sv
module sop_shift_flag_unit #(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opnd_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic [3:0]   cc_o
);
  localparam int H = W / 2;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  localparam logic [3:0] OP_CLR = 4'd0;
  localparam logic [3:0] OP_TST = 4'd1;
  localparam logic [3:0] OP_INC = 4'd2;
  localparam logic [3:0] OP_DEC = 4'd3;
  localparam logic [3:0] OP_ADC = 4'd4;
  localparam logic [3:0] OP_SBC = 4'd5;
  localparam logic [3:0] OP_ASL = 4'd6;
  localparam logic [3:0] OP_ASR = 4'd7;
  localparam logic [3:0] OP_ROR = 4'd8;
  localparam logic [3:0] OP_SWB = 4'd9;

  logic n, z, v, c;
  logic is_shift;

  assign is_shift = (op_i == OP_ASL) || (op_i == OP_ASR) || (op_i == OP_ROR);
  assign cc_o = {n, z, v, c};

  always_comb begin
    res_o = opnd_i;
    wr_o  = 1'b1;
    c     = 1'b0;
    v     = 1'b0;
    case (op_i)
      OP_CLR: res_o = '0;
      OP_TST: wr_o = 1'b0;
      OP_INC: begin
        res_o = opnd_i + 1'b1;
        c     = c_i;
        v     = (opnd_i == SMAX);
      end
      OP_DEC: begin
        res_o = opnd_i - 1'b1;
        c     = c_i;
        v     = (opnd_i == SMIN);
      end
      OP_ADC: begin
        {c, res_o} = {1'b0, opnd_i} + {{W{1'b0}}, c_i};
        v          = c_i && (opnd_i == SMAX);
      end
      OP_SBC: begin
        res_o = opnd_i - {{(W-1){1'b0}}, c_i};
        c     = c_i && (opnd_i == '0);
        v     = c_i && (opnd_i == SMIN);
      end
      OP_ASL: begin
        res_o = {opnd_i[W-2:0], 1'b0};
        c     = opnd_i[W-1];
      end
      OP_ASR: begin
        res_o = {opnd_i[W-1], opnd_i[W-1:1]};
        c     = opnd_i[0];
      end
      OP_ROR: begin
        res_o = {c_i, opnd_i[W-1:1]};
        c     = opnd_i[0];
      end
      OP_SWB: res_o = {opnd_i[H-1:0], opnd_i[W-1:H]};
      default: wr_o = 1'b0;
    endcase
    if (op_i == OP_SWB) begin
      n = res_o[H-1];
      z = (res_o[H-1:0] == '0);
    end else if (op_i > OP_SWB) begin
      n = 1'b0;
      z = 1'b0;
    end else begin
      n = res_o[W-1];
      z = (res_o == '0);
    end
    if (is_shift) v = n ^ c;
  end

  always_comb begin
    if (wr_o && op_i != OP_SWB)
      assert_nz_from_result_R2: assert (cc_o[3] == res_o[W-1] && cc_o[2] == (res_o == '0));
    if (is_shift)
      assert_shift_overflow_R6: assert (cc_o[1] == (cc_o[3] ^ cc_o[0]));
    if (op_i == OP_SWB)
      assert_swap_bytes_R7: assert (res_o[H-1:0] == opnd_i[W-1:H] && res_o[W-1:H] == opnd_i[H-1:0] && cc_o[1:0] == 2'b00);
    if (op_i == OP_INC || op_i == OP_DEC)
      assert_incdec_keeps_carry_R9: assert (cc_o[0] == c_i);
    if (op_i == OP_CLR)
      assert_clear_flags_R10: assert (res_o == '0 && cc_o == 4'b0100);
    if (op_i == OP_TST)
      assert_test_no_write_R11: assert (!wr_o && res_o == opnd_i && cc_o[1:0] == 2'b00);
    if (op_i > OP_SWB)
      assert_reserved_idle_R12: assert (!wr_o && res_o == opnd_i && cc_o == 4'b0000);
  end
endmodule

// File: tb/tb_sop_shift_flag_unit.sv
module tb_sop_shift_flag_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  op;
  logic [15:0] opnd;
  logic        cin;
  logic [15:0] res;
  logic        wr;
  logic [3:0]  cc;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sop_shift_flag_unit dut (.op_i(op), .opnd_i(opnd), .c_i(cin), .res_o(res), .wr_o(wr), .cc_o(cc));

  task automatic chk(input string req, input logic [3:0] o, input logic [15:0] d, input logic c,
                     input logic [15:0] er, input logic ew, input logic [3:0] ecc);
    @(posedge clk);
    #1;
    op = o; opnd = d; cin = c;
    @(negedge clk);
    checks++;
    if (res !== er || wr !== ew || cc !== ecc) begin
      errors++;
      $display("FAIL %s op=%0d d=%h c=%b: got res=%h wr=%b cc=%b, expected res=%h wr=%b cc=%b",
               req, o, d, c, res, wr, cc, er, ew, ecc);
    end
  endtask

  task automatic t_clear;
    chk("R10", 4'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'b0100);
    chk("R10", 4'd0, 16'hABCD, 1'b1, 16'h0000, 1'b1, 4'b0100);
  endtask

  task automatic t_test;
    chk("R11", 4'd1, 16'h8000, 1'b1, 16'h8000, 1'b0, 4'b1000);
    chk("R11", 4'd1, 16'h0000, 1'b1, 16'h0000, 1'b0, 4'b0100);
    chk("R11", 4'd1, 16'h0101, 1'b0, 16'h0101, 1'b0, 4'b0000);
  endtask

  task automatic t_incdec;
    chk("R9", 4'd2, 16'h7FFF, 1'b0, 16'h8000, 1'b1, 4'b1010);
    chk("R9", 4'd2, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 4'b0101);
    chk("R2", 4'd2, 16'h0005, 1'b0, 16'h0006, 1'b1, 4'b0000);
    chk("R9", 4'd3, 16'h8000, 1'b0, 16'h7FFF, 1'b1, 4'b0010);
    chk("R9", 4'd3, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 4'b1001);
    chk("R2", 4'd3, 16'h0001, 1'b0, 16'h0000, 1'b1, 4'b0100);
  endtask

  task automatic t_carry_arith;
    chk("R8", 4'd4, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 4'b0101);
    chk("R8", 4'd4, 16'h7FFF, 1'b1, 16'h8000, 1'b1, 4'b1010);
    chk("R8", 4'd4, 16'h1234, 1'b0, 16'h1234, 1'b1, 4'b0000);
    chk("R8", 4'd5, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 4'b1001);
    chk("R8", 4'd5, 16'h8000, 1'b1, 16'h7FFF, 1'b1, 4'b0010);
    chk("R8", 4'd5, 16'h0001, 1'b1, 16'h0000, 1'b1, 4'b0100);
  endtask

  task automatic t_shifts;
    chk("R3", 4'd6, 16'h8001, 1'b0, 16'h0002, 1'b1, 4'b0011);
    chk("R6", 4'd6, 16'h4000, 1'b1, 16'h8000, 1'b1, 4'b1010);
    chk("R3", 4'd6, 16'h8000, 1'b0, 16'h0000, 1'b1, 4'b0111);
    chk("R4", 4'd7, 16'h8001, 1'b0, 16'hC000, 1'b1, 4'b1001);
    chk("R4", 4'd7, 16'h0001, 1'b0, 16'h0000, 1'b1, 4'b0111);
    chk("R5", 4'd8, 16'h0001, 1'b1, 16'h8000, 1'b1, 4'b1001);
    chk("R5", 4'd8, 16'h0002, 1'b0, 16'h0001, 1'b1, 4'b0000);
    chk("R6", 4'd8, 16'h0001, 1'b0, 16'h0000, 1'b1, 4'b0111);
  endtask

  task automatic t_swap;
    chk("R7", 4'd9, 16'h12F0, 1'b1, 16'hF012, 1'b1, 4'b0000);
    chk("R7", 4'd9, 16'h8000, 1'b0, 16'h0080, 1'b1, 4'b1000);
    chk("R7", 4'd9, 16'h00FF, 1'b1, 16'hFF00, 1'b1, 4'b0100);
  endtask

  task automatic t_reserved;
    chk("R12", 4'd10, 16'h5A5A, 1'b1, 16'h5A5A, 1'b0, 4'b0000);
    chk("R12", 4'd15, 16'h0000, 1'b1, 16'h0000, 1'b0, 4'b0000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op = 4'd0; opnd = 16'h0000; cin = 1'b0;
    // R1 R13: packing and write strobe are covered across all scenarios below
    t_clear();
    t_test();
    t_incdec();
    t_carry_arith();
    t_shifts();
    t_swap();
    t_reserved();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule